// File: doc/BRIEF.md
# Indirect call target predictor

This block predicts where an indirect call will jump. A call site is identified by a few low bits of its source address. Those bits alone would allow only one target per site. The block therefore also mixes in the global branch history value, so that one call site can keep several targets, each tied to a different recent control-flow path. The wide history word is reduced to the index width by XOR-folding equal slices. The folded value is combined with source address bits [11:2] to select an entry. Each entry holds a valid flag, a tag and a full target address.

A fetch stage raises a lookup strobe together with the call's source address and the current history value. One clock later the block reports whether the table matched and gives a predicted target. When the table misses, the target offered on the generic-predictor input in the lookup cycle is forwarded instead, so the consumer always receives a usable target.

Once the call resolves, an update port writes the resolved target into the indexed entry. This happens only for indirect calls that were mispredicted.

Top module: `ind_call_pred`

## Requirements
- R1: While reset is asserted and after it is released, `lk_hit` is 0 and `lk_target` is 0 until the first lookup.
- R2: The entry index is fold(history) XOR source bits [11:2]. fold(h) has width 10, and bit k of fold(h) is the XOR of every history bit i with i mod 10 == k. Source bits above bit 11 have no effect on any lookup or update.
- R3: A lookup hits only when the indexed entry is valid and its stored tag {source[11:0], fold(history)} equals the tag of the lookup. Any other lookup misses.
- R4: On a miss, `lk_target` equals the `fb_target` value presented in the lookup cycle. On a hit, it equals the stored target.
- R5: Results appear on the first rising clock edge after the strobe and are held in registers.
- R6: In a cycle without `lk_valid`, the next edge clears `lk_hit` and leaves `lk_target` unchanged.
- R7: The table is written only when `up_valid`, `up_is_icall` and `up_mispred` are all 1. Any other update leaves the table unchanged.
- R8: A write overwrites the indexed entry whatever it held before. An aliasing entry with a different tag is therefore evicted.
- R9: One call site keeps distinct targets for history values whose folds differ, and each target is returned for its own history.
- R10: A lookup in the same cycle as a write to its entry sees the contents from before the write.
- R11: Flipping history bits i and i+10 together does not change the result of a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_src | input | 64 | Source address of the call being looked up |
| lk_hist | input | 58 | Global branch history at lookup |
| fb_target | input | 64 | Target from the generic predictor, used on a miss |
| lk_hit | output | 1 | Registered hit flag |
| lk_target | output | 64 | Registered predicted target |
| up_valid | input | 1 | Update strobe |
| up_is_icall | input | 1 | Resolved branch was an indirect call |
| up_mispred | input | 1 | Resolved branch was mispredicted |
| up_src | input | 64 | Source address of the resolved call |
| up_hist | input | 58 | History value that was used when the call was predicted |
| up_target | input | 64 | Resolved target |

## Verification
The hardest case to reach is an alias: two keys that select the same entry but carry different tags. The bench builds such pairs on purpose. It flips source bit 2 and history bit 0 together, which cancel in the index but not in the tag. It then checks that a lookup with the partner key misses, and that training the partner evicts the original. History pairs that fold to the same value are also built directly, as bits i and i+10. The same-cycle read/write case is reached by driving both ports with the same key in one cycle.

// File: rtl/icp_pkg.sv
package icp_pkg;
  localparam int DEF_ADDR_W    = 64;
  localparam int DEF_HIST_W    = 58;
  localparam int DEF_SRC_KEY_W = 12;
  localparam int DEF_IDX_LSB   = 2;
endpackage

// File: rtl/icp_key.sv
module icp_key #(
  parameter int SRC_KEY_W = icp_pkg::DEF_SRC_KEY_W,
  parameter int IDX_LSB   = icp_pkg::DEF_IDX_LSB,
  parameter int HIST_W    = icp_pkg::DEF_HIST_W,
  localparam int IDX_W    = SRC_KEY_W - IDX_LSB,
  localparam int TAG_W    = SRC_KEY_W + IDX_W
) (
  input  logic [SRC_KEY_W-1:0] src_lo,
  input  logic [HIST_W-1:0]    hist,
  output logic [IDX_W-1:0]     idx,
  output logic [TAG_W-1:0]     tag
);
  logic [IDX_W-1:0] folded;

  // XOR-fold the history into IDX_W bits; the last slice is implicitly zero-padded
  always_comb begin
    folded = '0;
    for (int i = 0; i < HIST_W; i++) begin
      folded[i % IDX_W] = folded[i % IDX_W] ^ hist[i];
    end
  end

  assign idx = folded ^ src_lo[SRC_KEY_W-1:IDX_LSB];
  assign tag = {src_lo, folded};
endmodule

// File: rtl/icp_table.sv
module icp_table #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 64,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DEPTH-1:0]  valid_q;
  logic [DEPTH-1:0]  valid_d;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  // read returns the contents from before any write in the same cycle
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_data  = data_mem[rd_idx];

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)
               && data_mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/ind_call_pred.sv
module ind_call_pred #(
  parameter int ADDR_W    = icp_pkg::DEF_ADDR_W,
  parameter int HIST_W    = icp_pkg::DEF_HIST_W,
  parameter int SRC_KEY_W = icp_pkg::DEF_SRC_KEY_W,
  parameter int IDX_LSB   = icp_pkg::DEF_IDX_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_src,
  input  logic [HIST_W-1:0] lk_hist,
  input  logic [ADDR_W-1:0] fb_target,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_valid,
  input  logic              up_is_icall,
  input  logic              up_mispred,
  input  logic [ADDR_W-1:0] up_src,
  input  logic [HIST_W-1:0] up_hist,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int IDX_W = SRC_KEY_W - IDX_LSB;
  localparam int TAG_W = SRC_KEY_W + IDX_W;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_data;
  logic              wr_en;
  logic              hit_d, hit_q;
  logic [ADDR_W-1:0] tgt_d, tgt_q;
  logic              unused_src_hi;

  assign unused_src_hi = ^{lk_src[ADDR_W-1:SRC_KEY_W], up_src[ADDR_W-1:SRC_KEY_W]};

  icp_key #(.SRC_KEY_W(SRC_KEY_W), .IDX_LSB(IDX_LSB), .HIST_W(HIST_W)) u_lk_key (
    .src_lo(lk_src[SRC_KEY_W-1:0]), .hist(lk_hist), .idx(lk_idx), .tag(lk_tag));

  icp_key #(.SRC_KEY_W(SRC_KEY_W), .IDX_LSB(IDX_LSB), .HIST_W(HIST_W)) u_up_key (
    .src_lo(up_src[SRC_KEY_W-1:0]), .hist(up_hist), .idx(up_idx), .tag(up_tag));

  assign wr_en = up_valid & up_is_icall & up_mispred;

  icp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_data(up_target));

  always_comb begin
    hit_d = lk_valid & rd_valid & (rd_tag == lk_tag);
    tgt_d = tgt_q;
    if (lk_valid) tgt_d = hit_d ? rd_data : fb_target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      hit_q <= hit_d;
      tgt_q <= tgt_d;
    end
  end

  assign lk_hit    = hit_q;
  assign lk_target = tgt_q;

  assert_idle_clears_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && $stable(lk_target)));

  assert_miss_forwards_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_hit || lk_target == $past(fb_target)));

  assert_hit_needs_valid_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !rd_valid) |=> !lk_hit);

  assert_hit_returns_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && rd_valid && rd_tag == lk_tag) |=> (lk_hit && lk_target == $past(rd_data)));
endmodule

// File: tb/ind_call_pred_bench.sv
`timescale 1ns/1ps
module ind_call_pred_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [63:0] lk_src;
  logic [57:0] lk_hist;
  logic [63:0] fb_target;
  logic        lk_hit;
  logic [63:0] lk_target;
  logic        up_valid, up_is_icall, up_mispred;
  logic [63:0] up_src;
  logic [57:0] up_hist;
  logic [63:0] up_target;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ind_call_pred u_ind_call_pred (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_src(lk_src), .lk_hist(lk_hist),
    .fb_target(fb_target), .lk_hit(lk_hit), .lk_target(lk_target),
    .up_valid(up_valid), .up_is_icall(up_is_icall), .up_mispred(up_mispred),
    .up_src(up_src), .up_hist(up_hist), .up_target(up_target));

  function automatic logic [9:0] bfold(input logic [57:0] h);
    logic [9:0] f = '0;
    for (int i = 0; i < 58; i++) f[i % 10] ^= h[i];
    return f;
  endfunction

  task automatic chk(input string req, input logic exp_hit, input logic [63:0] exp_tgt);
    n_checks++;
    if (lk_hit !== exp_hit || lk_target !== exp_tgt) begin
      n_fail++;
      $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
               req, lk_hit, lk_target, exp_hit, exp_tgt);
    end
  endtask

  // drive at negedge, result registered at next posedge, sampled at following negedge
  task automatic look(input logic [63:0] s, input logic [57:0] h, input logic [63:0] fb);
    lk_valid = 1'b1; lk_src = s; lk_hist = h; fb_target = fb;
    @(negedge clk);
    lk_valid = 1'b0; fb_target = 64'h0;
  endtask

  task automatic upd(input logic v, input logic ic, input logic mp,
                     input logic [63:0] s, input logic [57:0] h, input logic [63:0] t);
    up_valid = v; up_is_icall = ic; up_mispred = mp; up_src = s; up_hist = h; up_target = t;
    @(negedge clk);
    up_valid = 1'b0; up_is_icall = 1'b0; up_mispred = 1'b0;
  endtask

  task automatic train(input logic [63:0] s, input logic [57:0] h, input logic [63:0] t);
    upd(1'b1, 1'b1, 1'b1, s, h, t);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] sa, sb, tg;
    logic [57:0] ha, hb;
    rst_n = 1'b0; lk_valid = 1'b0; lk_src = '0; lk_hist = '0; fb_target = '0;
    up_valid = 1'b0; up_is_icall = 1'b0; up_mispred = 1'b0;
    up_src = '0; up_hist = '0; up_target = '0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 1'b0, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 64'h0);

    // empty table: every lookup misses and forwards the fallback (R4, R5)
    for (int j = 0; j < 8; j++) begin
      look(64'h4000 + 64'(j * 36), 58'(j * 977), 64'hF000_0000_0000_0000 + 64'(j));
      chk("R4 empty miss", 1'b0, 64'hF000_0000_0000_0000 + 64'(j));
    end

    // R2 sweep over call sites with history 0: distinct index per src[11:2]
    for (int j = 0; j < 32; j++) train(64'(j * 4 * 29), 58'h0, 64'hC000_0000_0000_0000 + 64'(j));
    for (int j = 0; j < 32; j++) begin
      look(64'(j * 4 * 29), 58'h0, 64'h1);
      chk("R2 site sweep hit", 1'b1, 64'hC000_0000_0000_0000 + 64'(j));
    end

    // R2 upper source bits ignored
    look(64'h1234_5600_0000_0000 | 64'(5 * 4 * 29), 58'h0, 64'h2);
    chk("R2 upper src bits ignored", 1'b1, 64'hC000_0000_0000_0005);

    // R6 idle cycle: hit clears, target holds
    @(negedge clk);
    chk("R6 idle", 1'b0, 64'hC000_0000_0000_0005);

    // R9 one call site, many histories (folds 1..16 with different indices)
    sa = 64'h0000_0000_0000_0A40;
    for (int k = 1; k <= 16; k++) train(sa, 58'(k) << 20, 64'hA000_0000_0000_0000 + 64'(k * 32'h1111));
    for (int k = 1; k <= 16; k++) begin
      look(sa, 58'(k) << 20, 64'h3);
      chk("R9 per-history target", 1'b1, 64'hA000_0000_0000_0000 + 64'(k * 32'h1111));
    end

    // R11 folding: flipping bit i and i+10 together is invisible
    for (int i = 0; i < 48; i += 7) begin
      ha = (58'(3) << 20) ^ (58'(1) << i) ^ (58'(1) << (i + 10));
      if (bfold(ha) != bfold(58'(3) << 20)) begin
        n_checks++; n_fail++;
        $display("FAIL R11 bench fold mismatch: %h expected %h", bfold(ha), bfold(58'(3) << 20));
      end
      look(sa, ha, 64'h4);
      chk("R11 folded pair", 1'b1, 64'hA000_0000_0000_0000 + 64'(3 * 32'h1111));
    end
    // single flip in the zero-padded top slice changes the key: miss
    look(sa, (58'(3) << 20) ^ (58'(1) << 57), 64'h5);
    chk("R3 single history flip misses", 1'b0, 64'h5);

    // R3/R8 alias: src bit2 and history bit0 flipped -> same index, different tag
    sa = 64'h0000_0000_0000_0F00; ha = 58'h2A5_5A5A;
    sb = sa ^ 64'h4;              hb = ha ^ 58'h1;
    if ((bfold(ha) ^ sa[11:2]) != (bfold(hb) ^ sb[11:2])) begin
      n_checks++; n_fail++;
      $display("FAIL R3 bench alias setup: idx differ, expected equal");
    end
    train(sa, ha, 64'hBEEF_0000_0000_0001);
    look(sa, ha, 64'h6);
    chk("R3 owner hits", 1'b1, 64'hBEEF_0000_0000_0001);
    look(sb, hb, 64'h7);
    chk("R3 alias tag mismatch misses", 1'b0, 64'h7);
    train(sb, hb, 64'hBEEF_0000_0000_0002);
    look(sa, ha, 64'h8);
    chk("R8 evicted owner misses", 1'b0, 64'h8);
    look(sb, hb, 64'h9);
    chk("R8 new owner hits", 1'b1, 64'hBEEF_0000_0000_0002);

    // R7 filtered updates leave the table alone
    sa = 64'h0000_0000_0000_0330; ha = 58'h3_0000_0000;
    upd(1'b1, 1'b0, 1'b1, sa, ha, 64'hDEAD_0000_0000_0001);
    look(sa, ha, 64'hA);
    chk("R7 non-call ignored", 1'b0, 64'hA);
    upd(1'b1, 1'b1, 1'b0, sa, ha, 64'hDEAD_0000_0000_0002);
    look(sa, ha, 64'hB);
    chk("R7 correct prediction ignored", 1'b0, 64'hB);
    upd(1'b0, 1'b1, 1'b1, sa, ha, 64'hDEAD_0000_0000_0003);
    look(sa, ha, 64'hC);
    chk("R7 no strobe ignored", 1'b0, 64'hC);

    // R10 same-cycle lookup and write see old contents
    sa = 64'h0000_0000_0000_0550; ha = 58'h1_2345;
    lk_valid = 1'b1; lk_src = sa; lk_hist = ha; fb_target = 64'hD;
    up_valid = 1'b1; up_is_icall = 1'b1; up_mispred = 1'b1;
    up_src = sa; up_hist = ha; up_target = 64'h7777_0000_0000_0001;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0; up_is_icall = 1'b0; up_mispred = 1'b0;
    chk("R10 read before write", 1'b0, 64'hD);
    look(sa, ha, 64'hE);
    chk("R10 write visible next", 1'b1, 64'h7777_0000_0000_0001);

    // R8 retrain same key with a new target
    train(sa, ha, 64'h7777_0000_0000_0002);
    look(sa, ha, 64'hF);
    chk("R8 overwrite same key", 1'b1, 64'h7777_0000_0000_0002);

    // R5 back-to-back lookups, one per cycle
    tg = 64'h0;
    lk_valid = 1'b1; lk_src = sa; lk_hist = ha; fb_target = 64'h10;
    @(negedge clk);
    chk("R5 back-to-back first", 1'b1, 64'h7777_0000_0000_0002);
    lk_src = 64'h0000_0000_0000_0FF8; lk_hist = 58'h3FF; fb_target = 64'h11;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R5 back-to-back second", 1'b0, 64'h11);

    // R1 reset clears table and outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", 1'b0, tg);
    rst_n = 1'b1;
    look(sa, ha, 64'h12);
    chk("R1 table empty after reset", 1'b0, 64'h12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule